// File: doc/BRIEF.md
# Way-Predicted Set-Associative Lookup

This block performs tag lookup and data selection for a four-way set-associative cache with 256 sets. Each set stores a small way guess. An incoming access compares its tag only against the guessed way, and that same guess steers the data multiplexer. When the guess is right, the access completes as a fast hit in the cycle after it is accepted. When the guess is wrong, the block raises `busy` for one cycle. It then compares the three remaining ways. If one of them matches, the block reports a late hit and retrains the guess for that set. If none matches, it reports a miss.

The tag, valid and data arrays are held in registers inside the block. A single-cycle refill port writes one way of one set. A refill also makes the written way the new guess for its set. The choice of victim way and the fetch from the next level are left to the surrounding logic.

Top module: `way_pred_lookup`

## Requirements
- R1: After reset, `busy`, `hit`, `miss` and `slowHit` are 0, every line is invalid and every set's guess is way 0. A lookup of any address then ends in a miss.
- R2: The address is split as follows. Bits [1:0] are a byte offset that plays no part in the lookup. Bits [9:2] select one of 256 sets. Bits [31:10] form the tag.
- R3: A lookup is accepted when `reqValid` is 1 and `busy` is 0. If the guessed way of the selected set is valid and its tag matches, then in the next cycle `hit`=1, `slowHit`=0, `miss`=0, `busy`=0, and `rdData` holds that way's data.
- R4: If the guessed way does not match, then in the next cycle `busy`=1 and `hit`=`miss`=0. If another valid way matches, then in the cycle after that `hit`=1, `slowHit`=1 and `rdData` holds that way's data.
- R5: A late hit makes the matching way the set's new guess. The next lookup of the same line is therefore a fast hit.
- R6: If no way of the set holds the tag, then `miss`=1 and `hit`=0 in the second cycle after acceptance.
- R7: A refill (`fillValid`=1) writes the tag, data and valid bit of way `fillWay` in the set taken from `fillAddr`. It also sets that set's guess to `fillWay`. Any line previously held in that way is replaced.
- R8: `busy` lasts exactly one cycle. A request presented while `busy`=1 is dropped: it produces no hit, no miss and no further busy cycle.
- R9: Guesses are kept per set. Training or refilling one set leaves the guess of every other set unchanged.
- R10: `hit`, `miss` and `slowHit` are single-cycle pulses, and `hit` and `miss` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Lookup byte address |
| fillValid | input | 1 | Refill write strobe |
| fillAddr | input | 32 | Refill byte address (selects tag and set) |
| fillWay | input | 2 | Way written by the refill |
| fillData | input | 32 | Refill line data |
| busy | output | 1 | Second compare in progress; new requests are dropped |
| hit | output | 1 | Lookup hit pulse |
| miss | output | 1 | Lookup miss pulse |
| slowHit | output | 1 | Marks a hit found in the second cycle |
| rdData | output | 32 | Data of the hitting way |

## Verification
The bench creates a guess mismatch in two ways. In one, a refill moves a set's guess to a way that does not hold the requested line. In the other, a late hit retrains the guess away from a line that is still resident. A design that compared only the guessed way would report these resident lines as misses. A design that skipped training would keep returning slow hits. A stray request is driven during every busy cycle. A design that accepted it would produce an extra pulse or a second busy cycle. The bench also refills a way that already holds a line, and checks that the old line now misses rather than returning stale data. Further cases cover the top and bottom set indices, a nonzero byte offset, and a refill in one set that must leave another set's guess unchanged.

// File: rtl/wp_lookup_pkg.sv
package wp_lookup_pkg;
  typedef struct packed {
    logic first;   // accepted request: guessed-way compare
    logic second;  // recheck of the remaining ways
  } lookupStrobe_t;

  typedef enum logic {
    ST_PRIMARY = 1'b0,
    ST_RECHECK = 1'b1
  } lookupState_t;
endpackage

// File: rtl/wp_lookup_ctrl.sv
module wp_lookup_ctrl
  import wp_lookup_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          firstMatch,
  output lookupStrobe_t strb,
  output logic          busy
);
  lookupState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_PRIMARY: if (reqValid && !firstMatch) nextState = ST_RECHECK;
      ST_RECHECK: nextState = ST_PRIMARY;
      default:    nextState = ST_PRIMARY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PRIMARY;
    else       state <= nextState;
  end

  assign busy        = (state == ST_RECHECK);
  assign strb.first  = reqValid && (state == ST_PRIMARY);
  assign strb.second = (state == ST_RECHECK);

  // R8: the recheck window is a single cycle
  a_r8_busy_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R4: busy only ever follows an offered request
  a_r4_busy_after_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
endmodule

// File: rtl/wp_lookup_dp.sv
module wp_lookup_dp
  import wp_lookup_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lookupStrobe_t     strb,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [SET_W-1:0]  reqSet,
  input  logic              fillValid,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [SET_W-1:0]  fillSet,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [DATA_W-1:0] fillData,
  output logic              firstMatch,
  output logic              hit,
  output logic              miss,
  output logic              slowHit,
  output logic [DATA_W-1:0] rdData
);
  logic [TAG_W-1:0]  tagArr  [SETS][WAYS];
  logic [DATA_W-1:0] dataArr [SETS][WAYS];
  logic [WAYS-1:0]   validArr[SETS];
  logic [WAY_W-1:0]  predArr [SETS];

  logic [TAG_W-1:0]  pendTag;
  logic [SET_W-1:0]  pendSet;
  logic [WAY_W-1:0]  pendWay;

  // first cycle: one compare, mux steered by the guess
  logic [WAY_W-1:0]  guessWay;
  logic [DATA_W-1:0] guessData;
  assign guessWay   = predArr[reqSet];
  assign guessData  = dataArr[reqSet][guessWay];
  assign firstMatch = validArr[reqSet][guessWay] && (tagArr[reqSet][guessWay] == reqTag);

  // second cycle: compare the remaining ways
  logic [WAYS-1:0] pendMatch, otherMatch;
  for (genvar g = 0; g < WAYS; g++) begin : g_recheck
    assign pendMatch[g] = validArr[pendSet][g] && (tagArr[pendSet][g] == pendTag);
  end
  assign otherMatch = pendMatch & ~(WAYS'(1) << pendWay);

  logic             secondHit;
  logic [WAY_W-1:0] secondWay;
  always_comb begin
    secondHit = 1'b0;
    secondWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!secondHit && otherMatch[w]) begin
        secondHit = 1'b1;
        secondWay = WAY_W'(w);
      end
    end
  end

  // arrays without reset
  always_ff @(posedge clk) begin
    if (fillValid) begin
      tagArr[fillSet][fillWay]  <= fillTag;
      dataArr[fillSet][fillWay] <= fillData;
    end
  end

  // valid bits and guesses; a refill overrides training of the same set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        predArr[s]  <= '0;
      end
    end else begin
      if (strb.second && secondHit) predArr[pendSet] <= secondWay;
      if (fillValid) begin
        validArr[fillSet][fillWay] <= 1'b1;
        predArr[fillSet]           <= fillWay;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTag <= '0;
      pendSet <= '0;
      pendWay <= '0;
      hit     <= 1'b0;
      miss    <= 1'b0;
      slowHit <= 1'b0;
      rdData  <= '0;
    end else if (strb.first) begin
      pendTag <= reqTag;
      pendSet <= reqSet;
      pendWay <= guessWay;
      hit     <= firstMatch;
      miss    <= 1'b0;
      slowHit <= 1'b0;
      rdData  <= guessData;
    end else if (strb.second) begin
      hit     <= secondHit;
      slowHit <= secondHit;
      miss    <= !secondHit;
      if (secondHit) rdData <= dataArr[pendSet][secondWay];
    end else begin
      hit     <= 1'b0;
      miss    <= 1'b0;
      slowHit <= 1'b0;
    end
  end

  // R10: hit and miss are exclusive
  a_r10_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && miss));

  // R4: a slow hit is always flagged together with hit
  a_r4_slow_is_hit: assert property (@(posedge clk) disable iff (!rstN)
    slowHit |-> hit);

  // R6: a miss is only reported after a recheck cycle
  a_r6_miss_after_recheck: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> $past(strb.second));

  // R5: a late hit retrains the guess of its set
  a_r5_guess_trained: assert property (@(posedge clk) disable iff (!rstN)
    (strb.second && secondHit && !fillValid) |=> (predArr[$past(pendSet)] == $past(secondWay)));
endmodule

// File: rtl/way_pred_lookup.sv
module way_pred_lookup
  import wp_lookup_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int OFF_W  = 2,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [DATA_W-1:0] fillData,
  output logic              busy,
  output logic              hit,
  output logic              miss,
  output logic              slowHit,
  output logic [DATA_W-1:0] rdData
);
  lookupStrobe_t strb;
  logic          firstMatch;
  logic          unusedOffsetBits;

  assign unusedOffsetBits = ^{reqAddr[OFF_W-1:0], fillAddr[OFF_W-1:0]};

  wp_lookup_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .firstMatch (firstMatch),
    .strb       (strb),
    .busy       (busy)
  );

  wp_lookup_dp #(
    .WAYS   (WAYS),
    .SETS   (SETS),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqTag     (reqAddr[ADDR_W-1 -: TAG_W]),
    .reqSet     (reqAddr[OFF_W +: SET_W]),
    .fillValid  (fillValid),
    .fillTag    (fillAddr[ADDR_W-1 -: TAG_W]),
    .fillSet    (fillAddr[OFF_W +: SET_W]),
    .fillWay    (fillWay),
    .fillData   (fillData),
    .firstMatch (firstMatch),
    .hit        (hit),
    .miss       (miss),
    .slowHit    (slowHit),
    .rdData     (rdData)
  );
endmodule

// File: tb/test_way_pred_lookup.sv
module test_way_pred_lookup;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        fillValid = 1'b0;
  logic [31:0] fillAddr = '0;
  logic [1:0]  fillWay = '0;
  logic [31:0] fillData = '0;
  logic        busy, hit, miss, slowHit;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  way_pred_lookup i_way_pred_lookup (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillWay(fillWay), .fillData(fillData),
    .busy(busy), .hit(hit), .miss(miss), .slowHit(slowHit), .rdData(rdData)
  );

  // vector: {op[1:0] (0 fill, 1 read), way[1:0], kind[1:0] (0 fast, 1 slow, 2 miss),
  //          tag[21:0], set[7:0], offset[1:0], data[31:0]}
  localparam int NV = 20;
  localparam logic [69:0] VEC [NV] = '{
    {2'd1, 2'd0, 2'd2, 22'd1, 8'd5,   2'd0, 32'h0},         // R1 empty cache misses
    {2'd0, 2'd0, 2'd0, 22'd1, 8'd5,   2'd0, 32'h0000_1111}, // R7 fill way0
    {2'd1, 2'd0, 2'd0, 22'd1, 8'd5,   2'd0, 32'h0000_1111}, // R3 fast hit
    {2'd0, 2'd2, 2'd0, 22'd2, 8'd5,   2'd0, 32'h0000_2222}, // R7 guess moves to way2
    {2'd1, 2'd0, 2'd0, 22'd2, 8'd5,   2'd0, 32'h0000_2222}, // R3
    {2'd1, 2'd0, 2'd1, 22'd1, 8'd5,   2'd0, 32'h0000_1111}, // R4 slow hit in way0
    {2'd1, 2'd0, 2'd0, 22'd1, 8'd5,   2'd0, 32'h0000_1111}, // R5 trained
    {2'd1, 2'd0, 2'd1, 22'd2, 8'd5,   2'd0, 32'h0000_2222}, // R4 R5 back to way2
    {2'd1, 2'd0, 2'd2, 22'd3, 8'd5,   2'd0, 32'h0},         // R6 absent tag
    {2'd0, 2'd3, 2'd0, 22'd7, 8'd9,   2'd0, 32'h0000_3333}, // R7 other set
    {2'd1, 2'd0, 2'd0, 22'd7, 8'd9,   2'd0, 32'h0000_3333}, // R3
    {2'd1, 2'd0, 2'd2, 22'd1, 8'd9,   2'd0, 32'h0},         // R6
    {2'd1, 2'd0, 2'd0, 22'd2, 8'd5,   2'd0, 32'h0000_2222}, // R9 set 5 guess untouched
    {2'd1, 2'd0, 2'd0, 22'd2, 8'd5,   2'd3, 32'h0000_2222}, // R2 offset ignored
    {2'd0, 2'd2, 2'd0, 22'd9, 8'd5,   2'd0, 32'h0000_4444}, // R7 replace way2
    {2'd1, 2'd0, 2'd2, 22'd2, 8'd5,   2'd0, 32'h0},         // R7 old line gone
    {2'd1, 2'd0, 2'd0, 22'd9, 8'd5,   2'd0, 32'h0000_4444}, // R3
    {2'd0, 2'd1, 2'd0, 22'd5, 8'd255, 2'd0, 32'h0000_5555}, // R2 top set
    {2'd1, 2'd0, 2'd0, 22'd5, 8'd255, 2'd0, 32'h0000_5555}, // R2
    {2'd1, 2'd0, 2'd2, 22'd5, 8'd0,   2'd0, 32'h0}          // R2 bottom set differs
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectOut(input string req, input logic eBusy, input logic eHit,
                           input logic eMiss, input logic eSlow);
    check({busy, hit, miss, slowHit} == {eBusy, eHit, eMiss, eSlow}, req,
          32'({busy, hit, miss, slowHit}), 32'({eBusy, eHit, eMiss, eSlow}));
  endtask

  task automatic doFill(input logic [31:0] addr, input logic [1:0] way, input logic [31:0] data);
    @(negedge clk);
    fillValid = 1'b1; fillAddr = addr; fillWay = way; fillData = data;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doRead(input logic [31:0] addr, input logic [1:0] kind, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    if (kind == 2'd0) begin
      expectOut("R3 fast hit flags", 1'b0, 1'b1, 1'b0, 1'b0);
      check(rdData == data, "R3 fast hit data", rdData, data);
    end else begin
      expectOut("R4 busy after mispredict", 1'b1, 1'b0, 1'b0, 1'b0);
      reqValid = 1'b1; reqAddr = {22'd1, 8'd5, 2'd0};  // stray request, R8
      @(negedge clk);
      reqValid = 1'b0;
      if (kind == 2'd1) begin
        expectOut("R4 slow hit flags", 1'b0, 1'b1, 1'b0, 1'b1);
        check(rdData == data, "R4 slow hit data", rdData, data);
      end else begin
        expectOut("R6 miss flags", 1'b0, 1'b0, 1'b1, 1'b0);
      end
      @(negedge clk);
      expectOut("R8 R10 stray dropped, pulse ends", 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expectOut("R1 reset outputs", 1'b0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R1 idle after reset", 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      if (v[69:68] == 2'd0) doFill(v[63:32], v[67:66], v[31:0]);
      else                  doRead(v[63:32], v[65:64], v[31:0]);
    end

    // R10: a fast hit pulse lasts one cycle
    doRead({22'd9, 8'd5, 2'd0}, 2'd0, 32'h0000_4444);
    @(negedge clk);
    expectOut("R10 hit pulse one cycle", 1'b0, 1'b0, 1'b0, 1'b0);

    // R9: refilling set 9 leaves set 255 guess on way1
    doFill({22'd8, 8'd9, 2'd0}, 2'd0, 32'h0000_6666);
    doRead({22'd5, 8'd255, 2'd0}, 2'd0, 32'h0000_5555);

    // R1: reset invalidates all lines
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doRead({22'd9, 8'd5, 2'd0}, 2'd2, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule